// File: doc/BRIEF.md
# ADC Sample Word Packer with DMA Handshake

This block sits between a 12-bit converter sample stream and a DMA engine. Each incoming sample carries a 3-bit channel tag. The block packs the samples into 32-bit words and places each finished word in a small word FIFO that the DMA engine drains. A precision mode sets how many bits of each sample are kept and how many samples fit in one word:

- In 8-bit mode, four samples share a word.
- In 10-bit and 12-bit modes, two samples share a word, each with its channel tag beside it.

A capture sequence works as follows. The DMA run input arms the block. A trigger pulse then starts capture. The block counts off a programmed number of samples. It closes the sequence by pushing any part-filled word and pulsing an end signal, so the DMA engine can move to its next transfer. The request output stays high as long as the FIFO holds a word. Samples that arrive while the FIFO is full are lost, and the block records this in a sticky flag.

Top module: `adc_word_packer`

## Requirements
- R1: From idle, a high `dma_run` moves the block to armed on the next edge. In armed, a high `trig` starts capture on the next edge. `trig` while idle, and `smp_valid` while idle or armed, are ignored: no word reaches the FIFO.
- R2: Mode 0 (8-bit) keeps the top 8 bits of each sample and puts four samples in a word. Sample k of the word sits at bits 8k+7:8k, with k from 0 to 3. No channel tag is stored.
- R3: Mode 1 (10-bit) keeps the top 10 bits of each sample. Sample 0 goes to bits 9:0 with its channel in bits 15:13. Sample 1 goes to bits 25:16 with its channel in bits 31:29.
- R4: Mode 2 (12-bit) keeps the full sample. Sample 0 goes to bits 11:0 with its channel in 15:13. Sample 1 goes to bits 27:16 with its channel in 31:29.
- R5: Mode 3 behaves as mode 2. Every bit position not named in R2 to R4 reads zero, including empty slots of a part-filled word.
- R6: A sequence is `seq_len` valid samples long. A `seq_len` of 0 counts as 1. Both `seq_len` and `mode` are captured at the trigger, so later changes to them do not affect the running sequence.
- R7: The word holding the final sample is pushed on the edge that accepts that sample, even if the word is only part filled. `dma_end` is high for exactly the one cycle after that edge, and the block is then idle.
- R8: `dma_req` is high exactly while the FIFO holds at least one word. A pop with `rd_en` presents the oldest word on `rd_data` after the same edge. `rd_en` on an empty FIFO changes nothing.
- R9: A sample that arrives while the FIFO is full is dropped but still counts toward the sequence length. A drop sets `overflow`, which stays set through the `dma_end` cycle and is clear from the cycle after.
- R10: After reset, `dma_req`, `dma_end` and `overflow` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_run | input | 1 | Arms the block from idle |
| trig | input | 1 | Starts capture while armed |
| mode | input | 2 | Precision: 0 = 8-bit, 1 = 10-bit, 2 or 3 = 12-bit |
| seq_len | input | LEN_W | Samples per sequence (0 counts as 1) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Raw converter sample |
| smp_chan | input | 3 | Channel tag of the sample |
| rd_en | input | 1 | Pop one word from the FIFO |
| rd_data | output | 32 | Word read out, registered |
| dma_req | output | 1 | FIFO not empty |
| dma_end | output | 1 | One-cycle end-of-sequence pulse |
| overflow | output | 1 | Sticky dropped-sample flag |

## Verification
The bench builds the block with a four-word FIFO and a 4-bit length field. It sweeps every mode code against every sequence length from 0 to 10, which covers part-filled final words in every slot position. Because the FIFO is that small, the 12-bit sequences of 9 and 10 samples overrun it, so sample drops, the sticky flag and the capped word count are reached by the same sweep. Directed runs add a mode change in mid-sequence, samples and triggers outside capture, and a pop from an empty FIFO.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
  localparam int WORD_W = 32;
  localparam int RAW_W  = 12;
  localparam int CH_W   = 3;

  typedef enum logic [1:0] {
    PM_8   = 2'd0,
    PM_10  = 2'd1,
    PM_12  = 2'd2,
    PM_12B = 2'd3
  } prec_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_CAPT  = 2'd2
  } seq_e;
endpackage

// File: rtl/adc_slot_field.sv
module adc_slot_field
  import adc_pack_pkg::*;
(
  input  prec_e                    mode,
  input  logic [1:0]               slot,
  input  logic [RAW_W-1:0]         data,
  input  logic [CH_W-1:0]          chan,
  output logic [WORD_W-1:0]        field
);
  localparam int HALF_W = WORD_W / 2;
  localparam int LANES  = WORD_W / 8;

  logic [HALF_W-1:0] half;
  logic [LANES-1:0][7:0] lane;

  // 8-bit mode: one byte lane per slot, top sample bits only
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = (slot == 2'(g)) ? data[RAW_W-1 -: 8] : 8'h00;
  end

  always_comb begin
    unique case (mode)
      PM_10:   half = {chan, 3'b000, data[RAW_W-1 -: 10]};
      default: half = {chan, 1'b0, data};
    endcase
    if (mode == PM_8) field = lane;
    else if (slot[0]) field = {half, {HALF_W{1'b0}}};
    else              field = {{HALF_W{1'b0}}, half};
  end
endmodule

// File: rtl/adc_word_fifo.sv
module adc_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // Storage without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
    if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_pack_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_run,
  input  logic             trig,
  input  logic [1:0]       mode_in,
  input  logic [LEN_W-1:0] seq_len,
  input  logic             smp_valid,
  input  logic             fifo_full,
  output prec_e            mode_q,
  output logic             start,
  output logic             accept,
  output logic             final_smp,
  output logic             end_q,
  output logic             ovf_q
);
  seq_e             st;
  logic [LEN_W-1:0] cnt, len_q;
  logic             take, drop;

  assign start     = (st == SQ_ARMED) && trig;
  assign take      = (st == SQ_CAPT) && smp_valid;
  assign accept    = take && !fifo_full;
  assign drop      = take && fifo_full;
  assign final_smp = take && (cnt == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      cnt    <= '0;
      len_q  <= LEN_W'(1);
      mode_q <= PM_8;
      end_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      end_q <= 1'b0;
      ovf_q <= (st == SQ_IDLE) ? 1'b0 : (ovf_q | drop);
      unique case (st)
        SQ_IDLE:  if (dma_run) st <= SQ_ARMED;
        SQ_ARMED: if (trig) begin
          st     <= SQ_CAPT;
          cnt    <= '0;
          len_q  <= (seq_len == '0) ? LEN_W'(1) : seq_len;
          mode_q <= prec_e'(mode_in);
        end
        SQ_CAPT: if (take) begin
          cnt <= cnt + 1'b1;
          if (final_smp) begin
            st    <= SQ_IDLE;
            end_q <= 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_word_asm.sv
module adc_word_asm
  import adc_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  prec_e             mode,
  input  logic              start,
  input  logic              accept,
  input  logic              final_smp,
  input  logic [RAW_W-1:0]  data,
  input  logic [CH_W-1:0]   chan,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic [WORD_W-1:0] acc, field;
  logic [1:0]        slot, last_slot;
  logic              closes;

  adc_slot_field u_field (
    .mode  (mode),
    .slot  (slot),
    .data  (data),
    .chan  (chan),
    .field (field)
  );

  assign last_slot = (mode == PM_8) ? 2'd3 : 2'd1;
  assign closes    = (slot == last_slot) || final_smp;
  assign push      = accept && closes;
  assign push_word = acc | field;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      acc  <= '0;
      slot <= '0;
    end else if (accept) begin
      if (closes) begin
        acc  <= '0;
        slot <= '0;
      end else begin
        acc  <= push_word;
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_word_packer.sv
module adc_word_packer
  import adc_pack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_run,
  input  logic             trig,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] seq_len,
  input  logic             smp_valid,
  input  logic [11:0]      smp_data,
  input  logic [2:0]       smp_chan,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic             dma_req,
  output logic             dma_end,
  output logic             overflow
);
  prec_e             mode_q;
  logic              start, accept, final_smp;
  logic              push, fifo_full, fifo_empty;
  logic [WORD_W-1:0] push_word;

  adc_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dma_run   (dma_run),
    .trig      (trig),
    .mode_in   (mode),
    .seq_len   (seq_len),
    .smp_valid (smp_valid),
    .fifo_full (fifo_full),
    .mode_q    (mode_q),
    .start     (start),
    .accept    (accept),
    .final_smp (final_smp),
    .end_q     (dma_end),
    .ovf_q     (overflow)
  );

  adc_word_asm u_asm (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .start     (start),
    .accept    (accept),
    .final_smp (final_smp),
    .data      (smp_data),
    .chan      (smp_chan),
    .push      (push),
    .push_word (push_word)
  );

  adc_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push),
    .wr_data (push_word),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  assign dma_req = !fifo_empty;
endmodule

// File: rtl/adc_word_packer_chk.sv
module adc_word_packer_chk (
  input logic        clk,
  input logic        rst,
  input logic        dma_end,
  input logic        dma_req,
  input logic        rd_en,
  input logic        overflow,
  input logic        push,
  input logic        fifo_full,
  input logic [31:0] push_word,
  input logic [1:0]  mode_q
);
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dma_end |=> !dma_end); // R7
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !rd_en) |=> dma_req); // R8
  AST_REQ_NEEDS_PUSH: assert property (@(posedge clk) disable iff (rst)
    (!dma_req && !push) |=> !dma_req); // R8
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    push |-> !fifo_full); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !dma_end) |=> overflow); // R9
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dma_end |=> !overflow); // R9
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (push && mode_q[1]) |-> (push_word[12] == 1'b0 && push_word[28] == 1'b0)); // R5
endmodule

bind adc_word_packer adc_word_packer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .dma_end   (dma_end),
  .dma_req   (dma_req),
  .rd_en     (rd_en),
  .overflow  (overflow),
  .push      (push),
  .fifo_full (fifo_full),
  .push_word (push_word),
  .mode_q    (mode_q)
);

// File: tb/adc_word_packer_tb.sv
module adc_word_packer_tb;
  localparam int DEPTH = 4;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_run = 1'b0, trig = 1'b0, smp_valid = 1'b0, rd_en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [LEN_W-1:0] seq_len = '0;
  logic [11:0] smp_data = '0;
  logic [2:0]  smp_chan = '0;
  logic [31:0] rd_data;
  logic dma_req, dma_end, overflow;

  int n_cmp = 0;
  int n_bad = 0;
  int sd [16];
  int sc [16];

  always #5 clk = ~clk;

  adc_word_packer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .dma_run(dma_run), .trig(trig), .mode(mode),
    .seq_len(seq_len), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan), .rd_en(rd_en), .rd_data(rd_data),
    .dma_req(dma_req), .dma_end(dma_end), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int m, input int w, input int n);
    logic [31:0] r = '0;
    int spw = (m == 0) ? 4 : 2;
    for (int k = 0; k < spw; k++) begin
      int idx = w * spw + k;
      if (idx < n) begin
        if (m == 0)      r = r | (32'(sd[idx] / 16) << (8 * k));
        else if (m == 1) r = r | (32'(sd[idx] / 4) << (16 * k)) | (32'(sc[idx]) << (13 + 16 * k));
        else             r = r | (32'(sd[idx]) << (16 * k)) | (32'(sc[idx]) << (13 + 16 * k));
      end
    end
    return r;
  endfunction

  // One full sequence from idle; FIFO expected empty at entry
  task automatic run_seq(input int m, input int len, input int seed, input bit flip);
    int n = (len == 0) ? 1 : len;
    int spw = (m == 0) ? 4 : 2;
    int cap = DEPTH * spw;
    int kept = (n < cap) ? n : cap;
    int words = (kept + spw - 1) / spw;
    for (int i = 0; i < n; i++) begin
      sd[i] = (i * 173 + seed * 59 + 7) % 4096;
      sc[i] = (i + seed) % 8;
    end
    dma_run = 1'b1;
    @(negedge clk);
    dma_run = 1'b0; trig = 1'b1; mode = 2'(m); seq_len = LEN_W'(len);
    @(negedge clk);
    trig = 1'b0;
    if (flip) begin mode = 2'(m ^ 2); seq_len = LEN_W'(15); end
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1; smp_data = 12'(sd[i]); smp_chan = 3'(sc[i]);
      @(negedge clk);
      if (i < n - 1) chk("R7 no early end", {31'b0, dma_end}, 32'd0);
    end
    smp_valid = 1'b0;
    chk("R7 end pulse", {31'b0, dma_end}, 32'd1);
    chk("R9 overflow at end", {31'b0, overflow}, {31'b0, n > cap});
    @(negedge clk);
    chk("R7 end one cycle", {31'b0, dma_end}, 32'd0);
    chk("R9 overflow cleared", {31'b0, overflow}, 32'd0);
    for (int w = 0; w < words; w++) begin
      chk("R8 req while data", {31'b0, dma_req}, 32'd1);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (m == 0)      chk("R2 word", rd_data, exp_word(0, w, kept));
      else if (m == 1) chk("R3 word", rd_data, exp_word(1, w, kept));
      else if (m == 2) chk("R4 word", rd_data, exp_word(2, w, kept));
      else             chk("R5 mode3 word", rd_data, exp_word(2, w, kept));
    end
    chk("R8 req low when drained", {31'b0, dma_req}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 req", {31'b0, dma_req}, 32'd0);
    chk("R10 end", {31'b0, dma_end}, 32'd0);
    chk("R10 overflow", {31'b0, overflow}, 32'd0);

    // R1: trigger and samples while idle, then samples while armed
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int i = 0; i < 4; i++) begin
      smp_valid = 1'b1; smp_data = 12'(i * 300);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    chk("R1 idle ignores", {31'b0, dma_req}, 32'd0);
    dma_run = 1'b1;
    @(negedge clk);
    dma_run = 1'b0;
    for (int i = 0; i < 8; i++) begin
      smp_valid = 1'b1; smp_data = 12'(i * 77);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    chk("R1 armed ignores samples", {31'b0, dma_req}, 32'd0);
    chk("R1 armed no end", {31'b0, dma_end}, 32'd0);
    // still armed: a trigger now starts a 2-sample 12-bit sequence
    run_seq(2, 2, 3, 1'b0);

    // R2..R6, R9 sweep: every mode code against lengths 0..10
    for (int m = 0; m < 4; m++)
      for (int len = 0; len <= 10; len++)
        run_seq(m, len, m * 16 + len, 1'b0);

    // R6: mode and length changed after the trigger
    run_seq(2, 5, 41, 1'b1);
    run_seq(0, 6, 42, 1'b1);

    // R8: pop on empty FIFO leaves output and request unchanged
    hold = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8 empty pop data", rd_data, hold);
    chk("R8 empty pop req", {31'b0, dma_req}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule